// File: doc/BRIEF.md
# Memory-Mapped Serial Port

This block is a serial port that sits on a memory-mapped peripheral window. It turns bytes written by the processor into asynchronous serial frames on a transmit line. It turns frames arriving on a receive line back into bytes, which wait in a small receive queue. Each frame has one start bit, eight data bits, no parity and one stop bit. The bit rate is fixed when the block is built: the clock frequency divided by the baud rate gives the number of clocks per bit. The defaults are 50 MHz and 115200 baud, which gives 434 clocks per bit.

The bus side has two channels, each with a valid/ready handshake. A request carries a write flag, a byte offset inside the window and a write byte. Exactly one response comes back for each request. Three offsets are decoded:

- Offset 0x0 is write-only and starts a transmission.
- Offset 0x4 is read-only. Reading it takes the oldest received byte out of the queue.
- Offset 0x8 is read-only status. It has only two live bits: transmitter busy, and receive data present.

Top module: `uart_mmio`

## Requirements
- R1: After reset, `uart_txd` is high, `req_ready` is high, `rsp_valid` is low, and a status read returns 0.
- R2: A write to offset 0x0 while the transmitter is idle sends one frame on `uart_txd`:
  - one low start bit, then the byte least significant bit first, then one high stop bit;
  - each bit lasts CLK_HZ/BAUD clocks (434 at the defaults);
  - status bit 0 reads 1 while the frame is in progress and 0 once the line has returned to idle.
- R3: A write to offset 0x0 while the transmitter is busy gets an error-free response, changes nothing in the frame in progress, and does not produce a later frame.
- R4: A read of offset 0x8 returns status: bit 0 is transmitter busy, bit 1 is 1 when the receive queue holds at least one byte, and all other bits are 0.
- R5: The receiver starts a frame on a falling edge of `uart_rxd` and samples each bit at its middle. Data bits arrive least significant bit first. A frame whose stop bit samples high puts its byte into the receive queue.
- R6: A frame whose stop bit samples low is discarded. A low pulse that has ended before the middle of the start bit is ignored.
- R7: A read of offset 0x4 returns the oldest queued byte in `rsp_rdata[7:0]`, with the upper bits 0, and removes that byte. Bytes come out in arrival order.
- R8: A read of offset 0x4 while the queue is empty returns 0 without error and leaves the queue unchanged.
- R9: The queue holds FIFO_DEPTH bytes (16 by default). A byte that completes while the queue is full is dropped, and the bytes already queued are kept.
- R10: Any other access returns `rsp_err` = 1 with `rsp_rdata` = 0 and has no side effect. This covers any other offset (including misaligned ones), a write to 0x4 or 0x8, and a read of 0x0.
- R11: A request is taken on a cycle where `req_valid` and `req_ready` are both high. Its response is valid on the next cycle. The response holds with stable data until `rsp_ready`, and `req_ready` stays low while a response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset inside the window |
| req_wdata | input | 8 | Byte to transmit |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Access not decoded |
| uart_rxd | input | 1 | Serial receive line |
| uart_txd | output | 1 | Serial transmit line, idle high |

## Verification
The bench builds the block with CLK_HZ = 1,600,000 and BAUD = 100,000, which gives 16 clocks per bit. This keeps each frame to 160 cycles, so dozens of random transmit and receive frames fit in a short run. It also sets FIFO_DEPTH = 4, so random traffic fills the queue repeatedly and exercises the drop-on-full rule and the empty read. Directed cases cover a start glitch shorter than half a bit, frames with a low stop bit, a write while busy, and a response held back by `rsp_ready`.

// File: rtl/uart_mmio.sv
module uart_mmio #(
  parameter int CLK_HZ     = 50_000_000,
  parameter int BAUD       = 115_200,
  parameter int FIFO_DEPTH = 16,
  parameter int ADDR_W     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  input  logic              uart_rxd,
  output logic              uart_txd
);

  localparam int BIT_CLKS = CLK_HZ / BAUD;
  localparam int HALF     = BIT_CLKS / 2;
  localparam int CNT_W    = $clog2(BIT_CLKS + 1);
  localparam int PTR_W    = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int FCNT_W   = $clog2(FIFO_DEPTH + 1);

  // bus decode
  logic acc, hit_tx, hit_rx, hit_st, bad;
  logic tx_busy, rx_avail, pop, push, tx_load;
  logic [7:0] head;

  assign req_ready = !rsp_valid;
  assign acc       = req_valid && req_ready;
  assign hit_tx    = req_we  && (req_addr == ADDR_W'(0));
  assign hit_rx    = !req_we && (req_addr == ADDR_W'(4));
  assign hit_st    = !req_we && (req_addr == ADDR_W'(8));
  assign bad       = !(hit_tx || hit_rx || hit_st);
  assign pop       = acc && hit_rx && rx_avail;
  assign tx_load   = acc && hit_tx && !tx_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else if (acc) begin
      rsp_valid <= 1'b1;
      rsp_err   <= bad;
      if (hit_rx)      rsp_rdata <= {24'b0, rx_avail ? head : 8'h00};
      else if (hit_st) rsp_rdata <= {30'b0, rx_avail, tx_busy};
      else             rsp_rdata <= '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // transmitter
  logic [9:0]       tx_sh;
  logic [3:0]       tx_bits;
  logic [CNT_W-1:0] tx_cnt;

  assign uart_txd = tx_sh[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_sh   <= '1;
      tx_bits <= '0;
      tx_cnt  <= '0;
      tx_busy <= 1'b0;
    end else if (tx_load) begin
      tx_sh   <= {1'b1, req_wdata, 1'b0};
      tx_bits <= '0;
      tx_cnt  <= '0;
      tx_busy <= 1'b1;
    end else if (tx_busy) begin
      if (tx_cnt == CNT_W'(BIT_CLKS - 1)) begin
        tx_cnt <= '0;
        tx_sh  <= {1'b1, tx_sh[9:1]};
        if (tx_bits == 4'd9) tx_busy <= 1'b0;
        else                 tx_bits <= tx_bits + 4'd1;
      end else begin
        tx_cnt <= tx_cnt + CNT_W'(1);
      end
    end
  end

  // receiver
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;
  rx_state_t        rx_st;
  logic             s1, s2, s3;
  logic [CNT_W-1:0] rx_cnt;
  logic [2:0]       rx_bits;
  logic [7:0]       rx_sh;
  logic             full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1; s3 <= 1'b1;
    end else begin
      s1 <= uart_rxd; s2 <= s1; s3 <= s2;
    end
  end

  assign push = (rx_st == RX_STOP) && (rx_cnt == CNT_W'(BIT_CLKS - 1)) && s2 && !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_st   <= RX_IDLE;
      rx_cnt  <= '0;
      rx_bits <= '0;
      rx_sh   <= '0;
    end else begin
      case (rx_st)
        RX_IDLE: if (!s2 && s3) begin
          rx_st  <= RX_START;
          rx_cnt <= '0;
        end
        RX_START: if (rx_cnt == CNT_W'(HALF - 1)) begin
          rx_cnt  <= '0;
          rx_bits <= '0;
          rx_st   <= s2 ? RX_IDLE : RX_DATA;
        end else rx_cnt <= rx_cnt + CNT_W'(1);
        RX_DATA: if (rx_cnt == CNT_W'(BIT_CLKS - 1)) begin
          rx_cnt <= '0;
          rx_sh  <= {s2, rx_sh[7:1]};
          if (rx_bits == 3'd7) rx_st <= RX_STOP;
          else                 rx_bits <= rx_bits + 3'd1;
        end else rx_cnt <= rx_cnt + CNT_W'(1);
        default: if (rx_cnt == CNT_W'(BIT_CLKS - 1)) begin
          rx_cnt <= '0;
          rx_st  <= RX_IDLE;
        end else rx_cnt <= rx_cnt + CNT_W'(1);
      endcase
    end
  end

  // receive queue
  logic [7:0]        mem [FIFO_DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [FCNT_W-1:0] fcnt;

  assign full     = (fcnt == FCNT_W'(FIFO_DEPTH));
  assign rx_avail = (fcnt != '0);
  assign head     = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= rx_sh;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fcnt   <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PTR_W'(FIFO_DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
      if (pop)  rd_ptr <= (rd_ptr == PTR_W'(FIFO_DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
      fcnt <= fcnt + FCNT_W'(push) - FCNT_W'(pop);
    end
  end

  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_err));
  // R11
  no_accept_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  // R9
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt <= FCNT_W'(FIFO_DEPTH));
  // R2
  tx_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> uart_txd);
  // R2
  tx_start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !uart_txd);
  // R10
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_rdata == 32'h0);
  // R9
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full && !pop |=> fcnt == FCNT_W'(FIFO_DEPTH));

endmodule

// File: tb/uart_mmio_tb.sv
module uart_mmio_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 1_600_000;
  localparam int BAUD       = 100_000;
  localparam int DEPTH      = 4;
  localparam int B          = CLK_HZ / BAUD;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, rsp_ready = 1'b1, uart_rxd = 1'b1;
  logic [11:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err, uart_txd;
  logic [31:0] rsp_rdata;

  int checks = 0, errors = 0;
  byte unsigned q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_mmio #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .FIFO_DEPTH(DEPTH), .ADDR_W(12)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .uart_rxd(uart_rxd), .uart_txd(uart_txd));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_status(input bit busy);
    return {30'b0, q.size() != 0, busy};
  endfunction

  task automatic bus_xfer(input bit we, input logic [11:0] addr, input logic [7:0] wd,
                          output logic [31:0] rd, output logic er);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = addr; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rd = rsp_rdata; er = rsp_err;
    chk(rsp_valid === 1'b1, "R11 rsp_valid after accept", {31'b0, rsp_valid}, 32'h1);
  endtask

  task automatic capture_tx(output logic [7:0] b, output bit ok);
    int w = 0;
    ok = 1'b1;
    while (uart_txd && w < 64) begin @(negedge clk); w++; end
    if (uart_txd) ok = 1'b0;
    repeat (B/2) @(negedge clk);
    if (uart_txd !== 1'b0) ok = 1'b0;
    for (int i = 0; i < 8; i++) begin
      repeat (B) @(negedge clk);
      b[i] = uart_txd;
    end
    repeat (B) @(negedge clk);
    if (uart_txd !== 1'b1) ok = 1'b0;
  endtask

  task automatic tx_test(input logic [7:0] d, input bit extra);
    logic [7:0] got;
    bit ok;
    logic [31:0] rd;
    logic er;
    fork
      capture_tx(got, ok);
      begin
        bus_xfer(1'b1, 12'h0, d, rd, er);
        chk(er === 1'b0, "R2 tx write err", {31'b0, er}, 32'h0);
        bus_xfer(1'b0, 12'h8, 8'h0, rd, er);
        chk(rd === exp_status(1'b1), "R4 status busy during frame", rd, exp_status(1'b1));
        if (extra) begin
          bus_xfer(1'b1, 12'h0, ~d, rd, er);
          chk(er === 1'b0, "R3 busy write response", {31'b0, er}, 32'h0);
        end
      end
    join
    chk(ok && got === d, "R2 tx frame", {23'b0, ok, got}, {24'h1, d});
    repeat (B) @(negedge clk);
    bus_xfer(1'b0, 12'h8, 8'h0, rd, er);
    chk(rd === exp_status(1'b0), "R2 busy clear after frame", rd, exp_status(1'b0));
    begin
      bit quiet = 1'b1;
      for (int i = 0; i < 3*B; i++) begin
        @(negedge clk);
        if (uart_txd !== 1'b1) quiet = 1'b0;
      end
      chk(quiet, "R3 no second frame", {31'b0, quiet}, 32'h1);
    end
  endtask

  task automatic send_frame(input logic [7:0] d, input bit stop_ok);
    @(negedge clk);
    uart_rxd = 1'b0;
    repeat (B) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      uart_rxd = d[i];
      repeat (B) @(negedge clk);
    end
    uart_rxd = stop_ok;
    repeat (B) @(negedge clk);
    uart_rxd = 1'b1;
    repeat (4) @(negedge clk);
    if (stop_ok && q.size() < DEPTH) q.push_back(d);
  endtask

  task automatic rx_read(input string req);
    logic [31:0] rd, exp;
    logic er;
    exp = (q.size() != 0) ? {24'b0, q.pop_front()} : 32'h0;
    bus_xfer(1'b0, 12'h4, 8'h0, rd, er);
    chk(rd === exp && er === 1'b0, req, rd, exp);
  endtask

  task automatic st_read(input string req);
    logic [31:0] rd;
    logic er;
    bus_xfer(1'b0, 12'h8, 8'h0, rd, er);
    chk(rd === exp_status(1'b0), req, rd, exp_status(1'b0));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic er;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(uart_txd === 1'b1 && req_ready === 1'b1 && rsp_valid === 1'b0, "R1 reset outputs",
        {29'b0, uart_txd, req_ready, rsp_valid}, 32'h6);
    st_read("R1 reset status");

    tx_test(8'hA5, 1'b0);
    tx_test(8'h01, 1'b1);
    tx_test(8'h80, 1'b1);

    rx_read("R8 empty read");
    st_read("R8 status after empty read");

    send_frame(8'h3C, 1'b1);
    st_read("R5 status after good frame");
    send_frame(8'hC3, 1'b1);
    rx_read("R7 first byte oldest");
    rx_read("R5 second byte");
    rx_read("R8 empty again");

    send_frame(8'h55, 1'b0);
    st_read("R6 bad stop discarded");
    @(negedge clk); uart_rxd = 1'b0;
    repeat (3) @(negedge clk); uart_rxd = 1'b1;
    repeat (3*B) @(negedge clk);
    st_read("R6 glitch ignored");

    for (int i = 0; i < DEPTH + 2; i++) send_frame(8'(8'h10 + i), 1'b1);
    chk(q.size() == DEPTH, "R9 model full", q.size(), DEPTH);
    for (int i = 0; i < DEPTH + 1; i++) rx_read("R9 kept bytes after overflow");

    bus_xfer(1'b1, 12'h4, 8'h77, rd, er);
    chk(er === 1'b1 && rd === 0, "R10 write to rx", {31'b0, er}, 32'h1);
    bus_xfer(1'b0, 12'h0, 8'h00, rd, er);
    chk(er === 1'b1 && rd === 0, "R10 read of tx", {31'b0, er}, 32'h1);
    bus_xfer(1'b0, 12'hC, 8'h00, rd, er);
    chk(er === 1'b1 && rd === 0, "R10 unmapped offset", {31'b0, er}, 32'h1);
    bus_xfer(1'b1, 12'h2, 8'h99, rd, er);
    chk(er === 1'b1, "R10 misaligned write", {31'b0, er}, 32'h1);
    repeat (B) @(negedge clk);
    chk(uart_txd === 1'b1, "R10 no frame from bad write", {31'b0, uart_txd}, 32'h1);
    st_read("R10 status unchanged");

    rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = 12'h8;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    rd = rsp_rdata;
    repeat (3) @(negedge clk);
    chk(rsp_valid === 1'b1 && req_ready === 1'b0 && rsp_rdata === rd, "R11 response held",
        {30'b0, rsp_valid, req_ready}, 32'h2);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(rsp_valid === 1'b0 && req_ready === 1'b1, "R11 response released",
        {30'b0, rsp_valid, req_ready}, 32'h1);

    for (int i = 0; i < 60; i++) begin
      int unsigned c = $urandom % 5;
      logic [7:0] d = 8'($urandom);
      case (c)
        0, 1: send_frame(d, 1'b1);
        2:    send_frame(d, ($urandom % 4) != 0);
        3:    rx_read("R7 random read");
        default: if (($urandom % 3) == 0) tx_test(d, $urandom % 2); else st_read("R4 random status");
      endcase
    end
    while (q.size() != 0) rx_read("R7 drain");
    rx_read("R8 final empty read");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule